// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block divides its clock by ten. It keeps its count in a five-bit twisted-ring register. On each counting edge the ring shifts by one place, and the inverse of its top bit is fed back into the bottom. Each of the ten legal ring patterns is decoded from one pair of bits into one line of a one-hot output vector. The lines light in turn from index 0 up to index 9 and then start again at 0.

A carry output is high for the first half of each ten-count cycle. It rises on the edge that wraps the count from 9 back to 0. That rising edge can act as the count-enable of a following stage, either through glue logic or by observing the rise, so several counters can be chained into a decimal divider.

Counting is gated by an active-low enable. An active-high reset acts asynchronously and returns the counter to count 0. A pattern outside the legal ring sequence can appear after a disturbance. The ring leaves such a pattern on the next counting edge.

Top module: `johnson_decade_counter`

## Requirements
- R1: While `cnt_en_n` is 0 and `rst_i` is 0, each rising edge of `clk` moves the count from k to (k+1) mod 10, so the lit line of `dec_o` moves from bit k to bit (k+1) mod 10.
- R2: While the ring holds a legal pattern, exactly one bit of `dec_o` is 1, and bit k is 1 exactly when the count is k.
- R3: While `cnt_en_n` is 1, rising edges of `clk` leave the count, `dec_o` and `carry_o` unchanged.
- R4: Raising `rst_i` forces `dec_o` to 10'b00_0000_0001 and `carry_o` to 1 at once, with no clock edge needed.
- R5: While `rst_i` is 1, clock edges do not advance the count, whatever the value of `cnt_en_n`. After release, counting resumes from count 0.
- R6: `carry_o` is 1 during counts 0 to 4 and 0 during counts 5 to 9. It rises only on the edge that wraps the count from 9 to 0.
- R7: The ring encoding is as follows. Bit 0 takes the inverse of bit 4 on each shift, and count 0 is 5'b00000. A ring pattern with more than one change between neighbouring bits (for example 5'b01010) is illegal. The first enabled clock edge that sees an illegal pattern loads count 0.
- R8: The decode of count k uses one pair of ring bits. Count 0 is bits 0 and 4 both 0. Count 5 is bits 0 and 4 both 1. Count k, for 1 to 4, is bit k-1 set and bit k clear. Count 5+k is bit k-1 clear and bit k set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; the state moves on its rising edge |
| rst_i | input | 1 | Asynchronous reset, active high; returns the counter to count 0 |
| cnt_en_n | input | 1 | Count enable, active low; when 1 the counter holds its state |
| dec_o | output | 10 | One-hot decode of the count; bit k is high at count k |
| carry_o | output | 1 | High for counts 0 to 4; rises on the wrap from 9 to 0 |

## Verification
Reset and an enabled counting edge can land in the same cycle. The bench provokes this by raising `rst_i` partway through a cycle with `cnt_en_n` low and holding it across two rising edges. It expects `dec_o` to read count 0 before any edge arrives and to stay there across both edges. A second collision is an illegal ring pattern that is still present when reset is released with counting enabled. Here the first edge must repair to count 0 rather than shift, and the reference model then follows the normal sequence from that point.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
   localparam int unsigned JDC_DEF_STAGES = 5;

   typedef enum logic [1:0] {
      RING_HOLD   = 2'd0,
      RING_SHIFT  = 2'd1,
      RING_REPAIR = 2'd2
   } ring_act_e;
endpackage

// File: rtl/jdc_ring.sv
module jdc_ring
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES = JDC_DEF_STAGES
) (
   input  logic              clk,
   input  logic              rst_i,
   input  logic              adv_en,
   output logic [STAGES-1:0] ring_q,
   output logic              legal_o
);
   localparam int unsigned NPAIR = STAGES - 1;
   localparam int unsigned CW    = $clog2(STAGES + 1);

   if (STAGES < 2) begin : g_bad_stages
      $error("jdc_ring: STAGES must be at least 2");
   end

   logic [NPAIR-1:0]  pair_diff;
   logic [CW-1:0]     diff_cnt;
   logic [STAGES-1:0] ring_d;
   ring_act_e         act;

   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      assign pair_diff[i] = ring_q[i] ^ ring_q[i+1];
   end

   always_comb begin
      diff_cnt = '0;
      for (int i = 0; i < NPAIR; i++) begin
         diff_cnt = diff_cnt + CW'(pair_diff[i]);
      end
   end

   assign legal_o = (diff_cnt <= CW'(1));

   always_comb begin
      if (!adv_en)       act = RING_HOLD;
      else if (!legal_o) act = RING_REPAIR;
      else               act = RING_SHIFT;
   end

   always_comb begin
      unique case (act)
         RING_SHIFT:  ring_d = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
         RING_REPAIR: ring_d = '0;
         default:     ring_d = ring_q;
      endcase
   end

   always_ff @(posedge clk or posedge rst_i) begin
      if (rst_i) ring_q <= '0;
      else       ring_q <= ring_d;
   end

   // R3
   hold_state_chk: assert property (@(posedge clk) disable iff (rst_i)
      !adv_en |=> $stable(ring_q));

   // R7
   repair_chk: assert property (@(posedge clk) disable iff (rst_i)
      (adv_en && !legal_o) |=> (ring_q == '0));
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
   parameter int unsigned STAGES = 5
) (
   input  logic [STAGES-1:0]   ring_i,
   output logic [2*STAGES-1:0] dec_o,
   output logic                carry_o
);
   localparam int unsigned TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("jdc_decode: STAGES must be at least 2");
   end

   assign dec_o[0]      = ~ring_i[0] & ~ring_i[TOP];
   assign dec_o[STAGES] =  ring_i[0] &  ring_i[TOP];

   for (genvar k = 1; k < STAGES; k++) begin : g_line
      assign dec_o[k]        =  ring_i[k-1] & ~ring_i[k];
      assign dec_o[STAGES+k] = ~ring_i[k-1] &  ring_i[k];
   end

   assign carry_o = ~ring_i[TOP];
endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES = JDC_DEF_STAGES
) (
   input  logic                clk,
   input  logic                rst_i,
   input  logic                cnt_en_n,
   output logic [2*STAGES-1:0] dec_o,
   output logic                carry_o
);
   localparam int unsigned OUTS = 2 * STAGES;
   localparam int unsigned HALF = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("johnson_decade_counter: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ring;
   logic              legal;

   jdc_ring #(.STAGES(STAGES)) u_ring (
      .clk     (clk),
      .rst_i   (rst_i),
      .adv_en  (~cnt_en_n),
      .ring_q  (ring),
      .legal_o (legal)
   );

   jdc_decode #(.STAGES(STAGES)) u_dec (
      .ring_i  (ring),
      .dec_o   (dec_o),
      .carry_o (carry_o)
   );

   // R2
   onehot_chk: assert property (@(posedge clk) disable iff (rst_i)
      legal |-> $onehot(dec_o));

   // R1
   rotate_chk: assert property (@(posedge clk) disable iff (rst_i)
      (!cnt_en_n && legal) |=>
         (dec_o == {$past(dec_o[OUTS-2:0]), $past(dec_o[OUTS-1])}));

   // R6
   carry_half_chk: assert property (@(posedge clk) disable iff (rst_i)
      legal |-> (carry_o == (|dec_o[HALF-1:0])));

   // R6
   carry_rise_chk: assert property (@(posedge clk) disable iff (rst_i)
      (legal && $rose(carry_o)) |-> dec_o[0]);

   // R4
   reset_state_chk: assert property (@(posedge clk)
      (rst_i && legal) |-> (dec_o == OUTS'(1) && carry_o));
endmodule

// File: tb/johnson_decade_counter_tb_top.sv
module johnson_decade_counter_tb_top;
   localparam int CLK_PER = 10;
   localparam int MAX_CYC = 20000;

   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic       en_n = 1'b1;
   logic [9:0] dec;
   logic       carry;

   int n_chk  = 0;
   int n_fail = 0;
   int model  = 0;
   bit cmp_on = 1'b0;
   bit repair_pend = 1'b0;
   bit done = 1'b0;

   johnson_decade_counter dut_i (
      .clk      (clk),
      .rst_i    (rst),
      .cnt_en_n (en_n),
      .dec_o    (dec),
      .carry_o  (carry)
   );

   always #(CLK_PER/2) clk = ~clk;

   // behavioural reference: integer count modulo ten
   always @(posedge clk or posedge rst) begin
      if (rst) model <= 0;
      else if (!en_n) begin
         if (repair_pend) begin
            model <= 0;
            repair_pend <= 1'b0;
         end else begin
            model <= (model + 1) % 10;
         end
      end
   end

   task automatic check(input string req, input logic [9:0] d, input logic c, input int cnt);
      logic [9:0] exp_d;
      logic       exp_c;
      exp_d = 10'(1) << cnt;
      exp_c = (cnt < 5);
      n_chk++;
      if (d !== exp_d || c !== exp_c) begin
         n_fail++;
         $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b", req, d, c, exp_d, exp_c);
      end
   endtask

   // per-cycle comparison: R1 R2 R3 R6 R8
   always @(negedge clk) begin
      if (cmp_on && !rst) check("R1/R2/R6", dec, carry, model);
   end

   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R4 reset state", dec, carry, 0);
      rst = 1'b0;
      cmp_on = 1'b1;

      // free run over several wraps
      en_n = 1'b0;
      repeat (27) @(negedge clk);

      // R3: patterned enable
      for (int i = 0; i < 30; i++) begin
         en_n = (i % 3 != 0);
         @(negedge clk);
      end
      en_n = 1'b1;
      begin
         logic [9:0] held;
         held = dec;
         repeat (4) @(negedge clk);
         n_chk++;
         if (dec !== held) begin
            n_fail++;
            $display("FAIL R3 hold: dec=%b expected %b", dec, held);
         end
      end

      // R6: carry rise lands on wrap
      en_n = 1'b0;
      while (model != 9) @(negedge clk);
      n_chk++;
      if (carry !== 1'b0) begin
         n_fail++;
         $display("FAIL R6 carry at 9: carry=%b expected 0", carry);
      end
      @(negedge clk);
      n_chk++;
      if (carry !== 1'b1 || dec !== 10'b1) begin
         n_fail++;
         $display("FAIL R6 wrap: carry=%b dec=%b expected 1 0000000001", carry, dec);
      end

      // R4/R5: async reset mid-cycle, overlapping enabled edges
      repeat (3) @(negedge clk);
      @(posedge clk);
      #(CLK_PER/4);
      rst = 1'b1;
      #1;
      check("R4 async reset", dec, carry, 0);
      repeat (2) @(posedge clk);
      #1;
      check("R5 reset overrides count", dec, carry, 0);
      @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R5 resume from 0", dec, carry, 4);

      // R7: illegal pattern present at reset release
      cmp_on = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      en_n = 1'b1;
      @(negedge clk);
      #1;
      force dut_i.u_ring.ring_q = 5'b01010;
      @(negedge clk);
      n_chk++;
      if ($countones(dec) == 1) begin
         n_fail++;
         $display("FAIL R8 illegal decode: dec=%b expected not one-hot", dec);
      end
      release dut_i.u_ring.ring_q;
      repair_pend = 1'b1;
      rst = 1'b0;
      en_n = 1'b0;
      @(negedge clk);
      check("R7 repair to 0", dec, carry, 0);
      cmp_on = 1'b1;
      repeat (12) @(negedge clk);

      cmp_on = 1'b0;
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < MAX_CYC) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected fewer than %0d", cyc, MAX_CYC);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule